// File: doc/BRIEF.md
# Serial-Programmed Frequency Margining Controller

This block is the digital control path of a clock synthesizer whose output can be stepped up or down from nominal. A three-wire serial port (a load strobe, a serial clock and a data line) shifts a 6-bit feedback divider value into a shift register. The falling edge of the load strobe commits that value. A margining-enable input selects what the loop uses. When it is low, the divider is the fixed nominal value 50. When it is high, the divider is the last committed value that lies in the supported window of 45 to 55.

The block reports three things: the active divider value, a signed percent-change code, and a flag that marks a rejected out-of-window value. It also runs a divide-by-M counter over an input tick stream. This counter emits a one-cycle feedback pulse for every M counted ticks, and it restarts whenever the active divider changes. The serial clock, load strobe, data and enable lines are asynchronous. They are brought into the system clock domain through two-flop synchronizers, and their edges are detected by comparing consecutive synchronized samples.

Top module: `fm_margin_ctrl`

## Requirements
- R1: After synchronous reset, the active divider is 50, the percent code is 0, the out-of-range flag is 0 and no feedback pulse is present.
- R2: While the synchronized load strobe is high, each synchronized rising edge of the serial clock shifts one data bit into a 6-bit shift register. The first bit shifted is the most significant divider bit, and the sixth is the least significant. A serial edge takes effect three system clocks after the raw input changes.
- R3: Only a synchronized high-to-low transition of the load strobe copies the shift register into the committed divider. Shifting with the strobe still high leaves the outputs unchanged.
- R4: While the load strobe is low, serial clock and data activity is ignored, and the shift register keeps its contents.
- R5: With the margining enable low, the active divider is 50 whatever has been committed, and leaving margining restores 50.
- R6: With the margining enable high, the active divider is the last committed in-window value. Values loaded while the enable is low are accepted and show up once it goes high.
- R7: The percent code is the 6-bit two's complement value 2*(M-50), from -10 for M=45 to +10 for M=55.
- R8: A committed value outside 45..55 sets the out-of-range flag and leaves the active divider at the last valid value. The next in-window commit clears the flag.
- R9: With the active divider steady at M, the feedback pulse lasts one cycle and arrives once every M asserted ticks.
- R10: When the active divider changes, the count restarts. The first pulse appears M+1 clocks after the change, with ticks asserted on every clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk_i | input | 1 | Serial shift clock (asynchronous) |
| ser_load_i | input | 1 | Serial load strobe; its falling edge commits |
| ser_dat_i | input | 1 | Serial data, most significant bit first |
| margin_en_i | input | 1 | 1 selects the programmed divider, 0 selects nominal |
| tick_i | input | 1 | Input tick counted by the divide-by-M counter |
| div_active_o | output | 6 | Active feedback divider value |
| pct_code_o | output | 6 | Signed percent change from nominal |
| out_of_range_o | output | 1 | Last commit was outside 45..55 |
| fb_pulse_o | output | 1 | One-cycle feedback pulse every M ticks |

## Verification
Raw serial and enable inputs pass two synchronizer flops and one edge-detect flop. A shift or commit therefore lands on the third clock after the input changes, and an enable change reaches the active divider on the second. The percent code follows the active divider in the same cycle. The feedback pulse is registered, so it appears one clock after the tick that completes the count. After an active divider change, the first pulse comes M+1 clocks later, because one clock goes to the reload. The bench keeps a history of raw inputs taken at each rising edge. Its reference model applies exactly these delays, and it compares every output at the falling edge. The directed checks wait out each latency before they sample.

// File: rtl/fm_pkg.sv
package fm_pkg;
    localparam int DIV_W     = 6;
    localparam int DIV_NOM   = 50;
    localparam int DIV_MIN   = 45;
    localparam int DIV_MAX   = 55;
    localparam int PCT_STEP  = 2;
    localparam int SYNC_LEN  = 2;
    localparam int LANES     = 4;

    typedef logic [DIV_W-1:0] div_t;

    // lane order of the synchronizer bus
    typedef enum int {LN_SCLK = 0, LN_LOAD = 1, LN_DAT = 2, LN_MODE = 3} lane_e;

    typedef struct packed {
        logic clk_rise;
        logic load_lvl;
        logic load_fall;
        logic dat;
        logic mode;
    } ser_evt_t;

    function automatic logic in_window(div_t m);
        return (int'(m) >= DIV_MIN) && (int'(m) <= DIV_MAX);
    endfunction

    function automatic div_t pct_of(div_t m);
        logic [DIV_W:0] d;
        d = {1'b0, m} - (DIV_W+1)'(DIV_NOM);
        return DIV_W'(d * (DIV_W+1)'(PCT_STEP));
    endfunction
endpackage

// File: rtl/fm_sync_edge.sv
module fm_sync_edge #(
    parameter int N      = fm_pkg::LANES,
    parameter int STAGES = fm_pkg::SYNC_LEN
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] raw_i,
    output logic [N-1:0] lvl_o,
    output logic [N-1:0] prv_o
);
    logic [N-1:0] stg [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) stg[0] <= '0;
                else     stg[0] <= raw_i;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) stg[s] <= '0;
                else     stg[s] <= stg[s-1];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) prv_o <= '0;
        else     prv_o <= stg[STAGES-1];
    end

    assign lvl_o = stg[STAGES-1];
endmodule

// File: rtl/fm_shift_latch.sv
module fm_shift_latch
    import fm_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  ser_evt_t ev_i,
    output div_t     valid_o,
    output logic     oor_o
);
    div_t sr_q;
    div_t valid_q;
    logic oor_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sr_q    <= div_t'(DIV_NOM);
            valid_q <= div_t'(DIV_NOM);
            oor_q   <= 1'b0;
        end else begin
            if (ev_i.clk_rise && ev_i.load_lvl)
                sr_q <= {sr_q[DIV_W-2:0], ev_i.dat};
            if (ev_i.load_fall) begin
                if (in_window(sr_q)) begin
                    valid_q <= sr_q;
                    oor_q   <= 1'b0;
                end else begin
                    oor_q   <= 1'b1;
                end
            end
        end
    end

    assign valid_o = valid_q;
    assign oor_o   = oor_q;

    // R4
    sr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !ev_i.load_lvl |=> $stable(sr_q));

    // R3
    commit_only_chk: assert property (@(posedge clk) disable iff (rst)
        !ev_i.load_fall |=> ($stable(valid_q) && $stable(oor_q)));

    // R8
    valid_window_chk: assert property (@(posedge clk) disable iff (rst)
        (int'(valid_q) >= DIV_MIN) && (int'(valid_q) <= DIV_MAX));
endmodule

// File: rtl/fm_div_counter.sv
module fm_div_counter
    import fm_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  div_t m_i,
    input  logic tick_i,
    output logic pulse_o
);
    div_t prev_q;
    div_t cnt_q;
    logic pulse_q;
    logic change;

    assign change = (m_i != prev_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q  <= div_t'(DIV_NOM);
            cnt_q   <= '0;
            pulse_q <= 1'b0;
        end else begin
            prev_q <= m_i;
            if (change) begin
                cnt_q   <= '0;
                pulse_q <= 1'b0;
            end else if (tick_i) begin
                if (cnt_q == m_i - div_t'(1)) begin
                    cnt_q   <= '0;
                    pulse_q <= 1'b1;
                end else begin
                    cnt_q   <= cnt_q + div_t'(1);
                    pulse_q <= 1'b0;
                end
            end else begin
                pulse_q <= 1'b0;
            end
        end
    end

    assign pulse_o = pulse_q;

    // R10
    reload_chk: assert property (@(posedge clk) disable iff (rst)
        change |=> (cnt_q == '0 && !pulse_q));

    // R9
    pulse_single_chk: assert property (@(posedge clk) disable iff (rst)
        pulse_q |=> !pulse_q);
endmodule

// File: rtl/fm_margin_ctrl.sv
module fm_margin_ctrl
    import fm_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             ser_clk_i,
    input  logic             ser_load_i,
    input  logic             ser_dat_i,
    input  logic             margin_en_i,
    input  logic             tick_i,
    output logic [DIV_W-1:0] div_active_o,
    output logic [DIV_W-1:0] pct_code_o,
    output logic             out_of_range_o,
    output logic             fb_pulse_o
);
    logic [LANES-1:0] raw, lvl, prv;
    ser_evt_t ev;
    div_t valid_m;
    div_t active;

    assign raw[LN_SCLK] = ser_clk_i;
    assign raw[LN_LOAD] = ser_load_i;
    assign raw[LN_DAT]  = ser_dat_i;
    assign raw[LN_MODE] = margin_en_i;

    fm_sync_edge #(.N(LANES), .STAGES(SYNC_LEN)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .raw_i (raw),
        .lvl_o (lvl),
        .prv_o (prv)
    );

    always_comb begin
        ev.clk_rise  = lvl[LN_SCLK] & ~prv[LN_SCLK];
        ev.load_lvl  = lvl[LN_LOAD];
        ev.load_fall = ~lvl[LN_LOAD] & prv[LN_LOAD];
        ev.dat       = lvl[LN_DAT];
        ev.mode      = lvl[LN_MODE];
    end

    fm_shift_latch u_latch (
        .clk     (clk),
        .rst     (rst),
        .ev_i    (ev),
        .valid_o (valid_m),
        .oor_o   (out_of_range_o)
    );

    assign active = ev.mode ? valid_m : div_t'(DIV_NOM);

    fm_div_counter u_div (
        .clk     (clk),
        .rst     (rst),
        .m_i     (active),
        .tick_i  (tick_i),
        .pulse_o (fb_pulse_o)
    );

    assign div_active_o = active;
    assign pct_code_o   = pct_of(active);

    // R5
    nominal_restore_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(ev.mode) |-> (div_active_o == div_t'(DIV_NOM)));
endmodule

// File: tb/sim_fm_margin_ctrl.sv
module sim_fm_margin_ctrl;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ser_clk = 1'b0, ser_load = 1'b0, ser_dat = 1'b0, men = 1'b0, tick = 1'b0;
    logic [5:0] act, pct;
    logic oor, pulse;

    int checks = 0;
    int bad = 0;

    always #5 clk = ~clk;

    fm_margin_ctrl u0 (
        .clk(clk), .rst(rst), .ser_clk_i(ser_clk), .ser_load_i(ser_load),
        .ser_dat_i(ser_dat), .margin_en_i(men), .tick_i(tick),
        .div_active_o(act), .pct_code_o(pct), .out_of_range_o(oor), .fb_pulse_o(pulse)
    );

    // behavioural reference model: input history plus plain integers
    int hc[4], hl[4], hd[4], hm[4];
    int m_sr, m_valid, m_oor, m_act, m_prev, m_cnt, m_pulse;

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 4; i++) begin hc[i]=0; hl[i]=0; hd[i]=0; hm[i]=0; end
            m_sr = 50; m_valid = 50; m_oor = 0; m_act = 50; m_prev = 50; m_cnt = 0; m_pulse = 0;
        end else begin
            int a_old;
            for (int i = 3; i > 0; i--) begin
                hc[i]=hc[i-1]; hl[i]=hl[i-1]; hd[i]=hd[i-1]; hm[i]=hm[i-1];
            end
            hc[0]=int'(ser_clk); hl[0]=int'(ser_load); hd[0]=int'(ser_dat); hm[0]=int'(men);
            a_old = m_act;
            if (hc[2]==1 && hc[3]==0 && hl[2]==1)
                m_sr = ((m_sr * 2) + hd[2]) % 64;
            else if (hl[3]==1 && hl[2]==0) begin
                if (m_sr >= 45 && m_sr <= 55) begin m_valid = m_sr; m_oor = 0; end
                else m_oor = 1;
            end
            m_act = (hm[1]==1) ? m_valid : 50;
            if (a_old != m_prev) begin
                m_cnt = 0; m_pulse = 0;
            end else if (tick) begin
                if (m_cnt == a_old - 1) begin m_cnt = 0; m_pulse = 1; end
                else begin m_cnt++; m_pulse = 0; end
            end else m_pulse = 0;
            m_prev = a_old;
        end
    end

    task automatic chk(string req, int got, int exp);
        checks++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", req, got, exp, $time);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (!rst) begin
            chk("R6 active", int'(act), m_act);
            chk("R7 pct", int'($signed(pct)), 2 * (m_act - 50));
            chk("R8 oor", int'(oor), m_oor);
            chk("R9 pulse", int'(pulse), m_pulse);
        end
    end

    task automatic wait_n(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic shift_bits(int v);
        ser_load = 1'b1;
        wait_n(4);
        for (int b = 5; b >= 0; b--) begin
            ser_dat = v[b];
            wait_n(4);
            ser_clk = 1'b1;
            wait_n(4);
            ser_clk = 1'b0;
            wait_n(4);
        end
    endtask

    task automatic drop_load();
        ser_load = 1'b0;
        wait_n(6);
    endtask

    task automatic send(int v);
        shift_bits(v);
        drop_load();
    endtask

    task automatic pulse_gap(int period, output int gap);
        int t0 = -1;
        gap = -1;
        for (int c = 0; c < 3000; c++) begin
            @(negedge clk);
            tick = ((c % period) == 0);
            if (pulse) begin
                if (t0 < 0) t0 = c;
                else begin gap = c - t0; break; end
            end
        end
    endtask

    task automatic change_gap(logic new_en, output int k);
        logic [5:0] last;
        last = act;
        tick = 1'b1;
        men = new_en;
        k = -1;
        for (int c = 0; c < 400; c++) begin
            @(negedge clk);
            if (k < 0) begin
                if (act != last) k = 0;
            end else begin
                k++;
                if (pulse) break;
            end
        end
    endtask

    initial begin
        int g;
        wait_n(5);
        rst = 1'b0;
        wait_n(1);
        // R1
        chk("R1 active", int'(act), 50);
        chk("R1 pct", int'($signed(pct)), 0);
        chk("R1 oor", int'(oor), 0);
        chk("R1 pulse", int'(pulse), 0);

        // R5: load while nominal, output stays nominal
        send(46);
        chk("R5 nominal while loaded", int'(act), 50);
        men = 1'b1; wait_n(4);
        // R2: MSB-first value 101110 = 46
        chk("R2 msb first", int'(act), 46);
        chk("R7 pct -8", int'($signed(pct)), -8);

        // R3: no change before strobe falls
        shift_bits(55);
        wait_n(6);
        chk("R3 no commit while high", int'(act), 46);
        drop_load();
        chk("R3 commit on fall", int'(act), 55);
        chk("R7 pct +10", int'($signed(pct)), 10);

        // R4: activity with strobe low is ignored
        for (int i = 0; i < 6; i++) begin
            ser_dat = i[0]; wait_n(4); ser_clk = 1'b1; wait_n(4); ser_clk = 1'b0; wait_n(4);
        end
        ser_load = 1'b1; wait_n(6); drop_load();
        chk("R4 shift register held", int'(act), 55);
        chk("R4 flag clear", int'(oor), 0);

        // R8: out-of-window commits
        send(60);
        chk("R8 flag set", int'(oor), 1);
        chk("R8 keep last valid", int'(act), 55);
        send(3);
        chk("R8 still set", int'(oor), 1);
        chk("R8 still last valid", int'(act), 55);
        send(45);
        chk("R8 flag cleared", int'(oor), 0);
        chk("R8 new valid", int'(act), 45);
        chk("R7 pct -10", int'($signed(pct)), -10);

        // R5 / R6
        men = 1'b0; wait_n(4);
        chk("R5 restore nominal", int'(act), 50);
        send(54);
        chk("R5 nominal after load", int'(act), 50);
        men = 1'b1; wait_n(4);
        chk("R6 programmed value", int'(act), 54);

        // R9
        pulse_gap(1, g);
        chk("R9 gap every tick", g, 54);
        pulse_gap(3, g);
        chk("R9 gap sparse ticks", g, 162);

        // R10
        change_gap(1'b0, g);
        chk("R10 reload to 50", g, 51);
        change_gap(1'b1, g);
        chk("R10 reload to 54", g, 55);

        tick = 1'b0;
        wait_n(5);
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end
endmodule